// File: doc/BRIEF.md
# Bounds-Checked Split Store Sequencer

This block takes one store at a time from the execute stage and turns it into one or two write transactions on a word-wide data bus. A store that crosses a word boundary, or one that is twice the bus word (a capability-sized store), goes out as two word-aligned pieces: the lower word first, then the next word up. Each piece carries its own byte enables and write data, both taken from the address offset and the access size.

Before anything reaches the bus, the whole access is checked against the authority that came with it: a base, an exclusive top and a write-permission bit. The check runs in the cycle the store is accepted and covers every byte of both pieces. A store that fails raises a one-cycle capability exception and produces no bus traffic. A store that passes keeps the check result in a register. The second piece's write enable comes from that register, so no combinational path runs from the authority inputs to the late bus request.

The bus uses request/grant for the address phase and a valid pulse with an error flag for the response. A response with the error flag set ends the sequence, and a second piece that has not gone out yet is never issued. A store that completes cleanly produces a one-cycle done pulse.

Top module: `split_store_unit`

## Requirements
- R1: The size code on `st_size_i` selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is a capability of 8 bytes (two words). Byte k of the store lands in byte lane (addr[1:0] + k) counted across the pair of words starting at the word-aligned address. Piece one goes to the word-aligned address. Piece two goes to that address plus 4.
- R2: A store is split into two pieces exactly when its bytes reach past the first word or its size is a capability. Otherwise it makes a single transaction.
- R3: `bus_wdata_o` carries byte k of `st_wdata_i` in the lane given by R1. For a capability store the low word goes with piece one and the high word with piece two.
- R4: A store is allowed only when all of these hold: `auth_wperm_i` is 1, `st_addr_i >= auth_base_i`, and `st_addr_i + bytes <= auth_top_i`. A capability store with a nonzero `st_addr_i[1:0]` is never allowed. The check covers the whole access, including any second piece.
- R5: A store that is not allowed raises no bus request at any time, and `cap_exc_o` pulses for one cycle in the cycle after acceptance.
- R6: An allowed store presents its first-piece request combinationally in its acceptance cycle. While `bus_req_o` is high and not granted, the address, byte enables and data stay unchanged.
- R7: The second piece is requested only after the first piece's response comes back without error. Its write enable comes from the check result registered at acceptance.
- R8: A response with `bus_err_i` set, on either piece, pulses `bus_err_o` in the next cycle. No further request follows and no done pulse is given.
- R9: `done_o` pulses for one cycle in the cycle after the last piece's error-free response. At most one of `done_o`, `cap_exc_o` and `bus_err_o` is high in any cycle.
- R10: `st_ready_o` is high only while no store is in progress. A request presented while busy is ignored.
- R11: After reset, `st_ready_o` is 1 and `bus_req_o`, `done_o`, `cap_exc_o` and `bus_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_valid_i | input | 1 | Store request present |
| st_ready_o | output | 1 | Sequencer idle, store accepted this cycle |
| st_addr_i | input | ADDR_W | Byte address of the store |
| st_size_i | input | 2 | Size code (R1) |
| st_wdata_i | input | 2*DATA_W | Store data, right-aligned |
| auth_base_i | input | ADDR_W | Lowest permitted byte address |
| auth_top_i | input | ADDR_W | Exclusive upper bound |
| auth_wperm_i | input | 1 | Write permission |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_addr_o | output | ADDR_W | Word-aligned bus address |
| bus_we_o | output | 1 | Write enable |
| bus_be_o | output | DATA_W/8 | Byte enables |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_rvalid_i | input | 1 | Response valid |
| bus_err_i | input | 1 | Response error flag |
| done_o | output | 1 | Store completed pulse |
| cap_exc_o | output | 1 | Capability exception pulse |
| bus_err_o | output | 1 | Bus error pulse |

## Verification
The in-RTL properties watch, on every cycle, that a request holds steady until granted, that a denied store never overlaps a bus request, that a second piece exists only under a passed and registered check, and that the three result pulses follow the right response and never overlap. Only the directed scenarios can show the bus contents: the lane placement and data for each size and offset, which stores split, the exact boundary cases of the bounds comparison, and the count of transactions after an error or while busy.

// File: rtl/sst_pkg.sv
`timescale 1ns/1ps
package sst_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_CAP  = 2'd3
   } sst_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_RSP  = 2'd2
   } sst_state_e;
endpackage

// File: rtl/sst_bounds_chk.sv
`timescale 1ns/1ps
// Whole-access authority check: permission, base, exclusive top, cap alignment.
module sst_bounds_chk
   import sst_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int NB     = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  sst_size_e         size_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] top_i,
   input  logic              wperm_i,
   output logic              ok_o
);
   localparam int OFF_W = $clog2(NB);

   logic [ADDR_W:0] span;
   logic [ADDR_W:0] end_excl;
   logic            cap_misal;

   always_comb begin
      case (size_i)
         SZ_BYTE: span = (ADDR_W+1)'(1);
         SZ_HALF: span = (ADDR_W+1)'(2);
         SZ_WORD: span = (ADDR_W+1)'(4);
         default: span = (ADDR_W+1)'(2*NB);
      endcase
   end

   // one bit wider so an access ending exactly at the top of memory compares right
   assign end_excl  = {1'b0, addr_i} + span;
   assign cap_misal = (size_i == SZ_CAP) && (addr_i[OFF_W-1:0] != '0);
   assign ok_o      = wperm_i && (addr_i >= base_i) &&
                      (end_excl <= {1'b0, top_i}) && !cap_misal;
endmodule

// File: rtl/sst_lane_split.sv
`timescale 1ns/1ps
// Places store bytes over a pair of bus words and reports whether the pair is needed.
module sst_lane_split
   import sst_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [$clog2(DATA_W/8)-1:0] off_i,
   input  sst_size_e                   size_i,
   input  logic [2*DATA_W-1:0]         data_i,
   output logic [DATA_W/8-1:0]         be_lo_o,
   output logic [DATA_W/8-1:0]         be_hi_o,
   output logic [DATA_W-1:0]           d_lo_o,
   output logic [DATA_W-1:0]           d_hi_o,
   output logic                        split_o
);
   localparam int NB    = DATA_W / 8;
   localparam int LANES = 2 * NB;
   localparam int CW    = $clog2(LANES) + 2;

   logic [CW-1:0]        span;
   logic [CW-1:0]        first;
   logic [CW-1:0]        last_excl;
   logic [LANES-1:0]     lane_en;
   logic [2*DATA_W-1:0]  shifted;

   always_comb begin
      case (size_i)
         SZ_BYTE: span = CW'(1);
         SZ_HALF: span = CW'(2);
         SZ_WORD: span = CW'(4);
         default: span = CW'(LANES);
      endcase
   end

   assign first     = CW'(off_i);
   assign last_excl = first + span;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_en[g] = (CW'(g) >= first) && (CW'(g) < last_excl);
   end

   assign shifted = data_i << {off_i, 3'b000};
   assign be_lo_o = lane_en[NB-1:0];
   assign be_hi_o = lane_en[LANES-1:NB];
   assign d_lo_o  = shifted[DATA_W-1:0];
   assign d_hi_o  = shifted[2*DATA_W-1:DATA_W];
   assign split_o = |lane_en[LANES-1:NB];
endmodule

// File: rtl/split_store_unit.sv
`timescale 1ns/1ps
module split_store_unit
   import sst_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  st_valid_i,
   output logic                  st_ready_o,
   input  logic [ADDR_W-1:0]     st_addr_i,
   input  logic [1:0]            st_size_i,
   input  logic [2*DATA_W-1:0]   st_wdata_i,
   input  logic [ADDR_W-1:0]     auth_base_i,
   input  logic [ADDR_W-1:0]     auth_top_i,
   input  logic                  auth_wperm_i,
   output logic                  bus_req_o,
   input  logic                  bus_gnt_i,
   output logic [ADDR_W-1:0]     bus_addr_o,
   output logic                  bus_we_o,
   output logic [DATA_W/8-1:0]   bus_be_o,
   output logic [DATA_W-1:0]     bus_wdata_o,
   input  logic                  bus_rvalid_i,
   input  logic                  bus_err_i,
   output logic                  done_o,
   output logic                  cap_exc_o,
   output logic                  bus_err_o
);
   localparam int NB    = DATA_W / 8;
   localparam int OFF_W = $clog2(NB);

   if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("split_store_unit: DATA_W must be a power of two of at least 32");
   end
   if (ADDR_W <= OFF_W + 1) begin : g_bad_addr_w
      $error("split_store_unit: ADDR_W too small for the word offset");
   end

   sst_size_e           size_c;
   logic                ok_c;
   logic [NB-1:0]       be_lo_c, be_hi_c;
   logic [DATA_W-1:0]   d_lo_c, d_hi_c;
   logic                split_c;
   logic [ADDR_W-1:0]   word_addr_c;

   assign size_c      = sst_size_e'(st_size_i);
   assign word_addr_c = {st_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   sst_bounds_chk #(.ADDR_W(ADDR_W), .NB(NB)) u_chk (
      .addr_i  (st_addr_i),
      .size_i  (size_c),
      .base_i  (auth_base_i),
      .top_i   (auth_top_i),
      .wperm_i (auth_wperm_i),
      .ok_o    (ok_c)
   );

   sst_lane_split #(.DATA_W(DATA_W)) u_lanes (
      .off_i   (st_addr_i[OFF_W-1:0]),
      .size_i  (size_c),
      .data_i  (st_wdata_i),
      .be_lo_o (be_lo_c),
      .be_hi_o (be_hi_c),
      .d_lo_o  (d_lo_c),
      .d_hi_o  (d_hi_c),
      .split_o (split_c)
   );

   sst_state_e          state_q, state_d;
   logic                piece_q, piece_d;
   logic                ok_q, split_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [NB-1:0]       be_lo_q, be_hi_q;
   logic [DATA_W-1:0]   d_lo_q, d_hi_q;
   logic                done_d, exc_d, err_d;
   logic                done_q, exc_q, err_q;
   logic                accept;

   assign accept = (state_q == ST_IDLE) && st_valid_i;

   always_comb begin
      state_d = state_q;
      piece_d = piece_q;
      done_d  = 1'b0;
      exc_d   = 1'b0;
      err_d   = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (st_valid_i) begin
               piece_d = 1'b0;
               if (!ok_c)          exc_d   = 1'b1;
               else if (bus_gnt_i) state_d = ST_RSP;
               else                state_d = ST_REQ;
            end
         end
         ST_REQ: begin
            if (bus_gnt_i) state_d = ST_RSP;
         end
         ST_RSP: begin
            if (bus_rvalid_i) begin
               if (bus_err_i) begin
                  err_d   = 1'b1;
                  state_d = ST_IDLE;
               end else if (!piece_q && split_q) begin
                  piece_d = 1'b1;
                  state_d = ST_REQ;
               end else begin
                  done_d  = 1'b1;
                  state_d = ST_IDLE;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         piece_q <= 1'b0;
         ok_q    <= 1'b0;
         split_q <= 1'b0;
         addr_q  <= '0;
         be_lo_q <= '0;
         be_hi_q <= '0;
         d_lo_q  <= '0;
         d_hi_q  <= '0;
         done_q  <= 1'b0;
         exc_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         piece_q <= piece_d;
         done_q  <= done_d;
         exc_q   <= exc_d;
         err_q   <= err_d;
         if (accept) begin
            ok_q    <= ok_c;
            split_q <= split_c;
            addr_q  <= word_addr_c;
            be_lo_q <= be_lo_c;
            be_hi_q <= be_hi_c;
            d_lo_q  <= d_lo_c;
            d_hi_q  <= d_hi_c;
         end
      end
   end

   // First piece leaves straight from the inputs; everything later uses the registered copy.
   always_comb begin
      if (state_q == ST_IDLE) begin
         bus_req_o   = st_valid_i && ok_c;
         bus_we_o    = ok_c;
         bus_addr_o  = word_addr_c;
         bus_be_o    = be_lo_c;
         bus_wdata_o = d_lo_c;
      end else begin
         bus_req_o   = (state_q == ST_REQ);
         bus_we_o    = ok_q;
         bus_addr_o  = piece_q ? addr_q + ADDR_W'(NB) : addr_q;
         bus_be_o    = piece_q ? be_hi_q : be_lo_q;
         bus_wdata_o = piece_q ? d_hi_q  : d_lo_q;
      end
   end

   assign st_ready_o = (state_q == ST_IDLE);
   assign done_o     = done_q;
   assign cap_exc_o  = exc_q;
   assign bus_err_o  = err_q;

   p_be_nonempty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_req_o |-> (bus_be_o != '0));

   p_exc_quiet_bus_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_exc_o |-> $past(!bus_req_o));

   p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                     $stable(bus_be_o) && $stable(bus_wdata_o)));

   p_second_piece_ok_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_REQ && piece_q) |-> (ok_q && split_q && bus_we_o));

   p_err_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_RSP && bus_rvalid_i && bus_err_i) |=> (state_q == ST_IDLE && bus_err_o));

   p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_err_o |-> $past(bus_rvalid_i && bus_err_i));

   p_done_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> $past(bus_rvalid_i && !bus_err_i));

   p_pulse_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({done_o, cap_exc_o, bus_err_o}));

   p_busy_not_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_o && bus_gnt_i) |=> !st_ready_o);
endmodule

// File: tb/split_store_unit_tb_top.sv
`timescale 1ns/1ps
module split_store_unit_tb_top;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int NB = DW / 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n;
   logic          st_valid, st_ready;
   logic [AW-1:0] st_addr, auth_base, auth_top;
   logic [1:0]    st_size;
   logic [2*DW-1:0] st_wdata;
   logic          auth_wperm;
   logic          bus_req, bus_gnt, bus_we, bus_rvalid, bus_err_in;
   logic [AW-1:0] bus_addr;
   logic [NB-1:0] bus_be;
   logic [DW-1:0] bus_wdata;
   logic          done, cap_exc, bus_err_out;

   split_store_unit #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
      .st_size_i(st_size), .st_wdata_i(st_wdata),
      .auth_base_i(auth_base), .auth_top_i(auth_top), .auth_wperm_i(auth_wperm),
      .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_addr_o(bus_addr),
      .bus_we_o(bus_we), .bus_be_o(bus_be), .bus_wdata_o(bus_wdata),
      .bus_rvalid_i(bus_rvalid), .bus_err_i(bus_err_in),
      .done_o(done), .cap_exc_o(cap_exc), .bus_err_o(bus_err_out)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // bus model and event log
   logic [AW-1:0] t_addr [4];
   logic [NB-1:0] t_be   [4];
   logic [DW-1:0] t_data [4];
   logic          t_we   [4];
   int n_txn, n_done, n_exc, n_err;
   int cyc = 0, acc_cyc, rv_cyc, done_cyc, exc_cyc, err_cyc;
   bit pend = 0, gnt_always = 0;
   int err_at = -1, stall_left = 0;

   always @(posedge clk) begin
      cyc++;
      if (st_valid && st_ready) acc_cyc = cyc;
      if (bus_rvalid) rv_cyc = cyc;
      if (done)        begin n_done++; done_cyc = cyc; end
      if (cap_exc)     begin n_exc++;  exc_cyc  = cyc; end
      if (bus_err_out) begin n_err++;  err_cyc  = cyc; end
      if (rst_n && bus_req && bus_gnt) begin
         if (n_txn < 4) begin
            t_addr[n_txn] = bus_addr; t_be[n_txn] = bus_be;
            t_data[n_txn] = bus_wdata; t_we[n_txn] = bus_we;
         end
         n_txn++;
         pend = 1;
      end
      #1;
      bus_rvalid = 1'b0;
      bus_err_in = 1'b0;
      if (pend) begin
         bus_rvalid = 1'b1;
         bus_err_in = ((n_txn - 1) == err_at);
         pend = 0;
      end
      if (gnt_always) bus_gnt = 1'b1;
      else if (bus_req) begin
         if (stall_left > 0) begin stall_left--; bus_gnt = 1'b0; end
         else bus_gnt = 1'b1;
      end else bus_gnt = 1'b0;
   end

   task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      end
   endtask

   task automatic clear_log();
      n_txn = 0; n_done = 0; n_exc = 0; n_err = 0;
      acc_cyc = -1; rv_cyc = -1; done_cyc = -1; exc_cyc = -1; err_cyc = -1;
   endtask

   // one store; expected values come from R1..R4 and the bus rules R5..R9
   task automatic run_store(input string tag, input logic [AW-1:0] a, input logic [1:0] sz,
                            input logic [63:0] wd, input logic [AW-1:0] b, input logic [AW-1:0] t,
                            input logic perm, input bit exp_ok, input int e_at,
                            input int stall, input bit galw);
      int span, off, full_n, exp_n;
      bit exp_err;
      logic [2*NB-1:0] m;
      logic [63:0] ed;
      logic [NB-1:0] ebe;
      logic [DW-1:0] edw, mw;
      span = (sz == 2'd3) ? 2*NB : (1 << sz);
      off  = int'(a[1:0]);
      m = '0; ed = '0;
      for (int i = 0; i < span; i++) begin
         m[off+i] = 1'b1;
         ed[(off+i)*8 +: 8] = wd[i*8 +: 8];
      end
      full_n  = (m[2*NB-1:NB] != '0) ? 2 : 1;
      exp_err = exp_ok && (e_at >= 0) && (e_at < full_n);
      exp_n   = !exp_ok ? 0 : (exp_err ? e_at + 1 : full_n);

      @(negedge clk);
      clear_log();
      err_at = e_at; stall_left = stall; gnt_always = galw;
      if (galw) bus_gnt = 1'b1;
      st_addr = a; st_size = sz; st_wdata = wd;
      auth_base = b; auth_top = t; auth_wperm = perm; st_valid = 1'b1;
      #1;
      check(tag, "ready before accept (R10)", st_ready, 1);
      check(tag, "first request in accept cycle (R5/R6)", bus_req, exp_ok);
      @(negedge clk);
      st_valid = 1'b0;
      if (!galw || !exp_ok) check(tag, "ready after accept (R10)", st_ready, !exp_ok);
      repeat (30) @(negedge clk);
      gnt_always = 0;
      check(tag, "transaction count (R2/R5/R8)", n_txn, exp_n);
      for (int p = 0; p < exp_n && p < 2; p++) begin
         ebe = p ? m[2*NB-1:NB] : m[NB-1:0];
         edw = p ? ed[2*DW-1:DW] : ed[DW-1:0];
         mw  = '0;
         for (int j = 0; j < NB; j++) if (ebe[j]) mw[j*8 +: 8] = 8'hFF;
         check(tag, $sformatf("piece %0d address (R1)", p), t_addr[p], {a[AW-1:2], 2'b00} + AW'(4*p));
         check(tag, $sformatf("piece %0d byte enables (R1)", p), t_be[p], ebe);
         check(tag, $sformatf("piece %0d data (R3)", p), t_data[p] & mw, edw & mw);
         check(tag, $sformatf("piece %0d write enable (R7)", p), t_we[p], 1);
      end
      check(tag, "done count (R9)", n_done, (exp_ok && !exp_err) ? 1 : 0);
      check(tag, "exception count (R5)", n_exc, exp_ok ? 0 : 1);
      check(tag, "bus error count (R8)", n_err, exp_err ? 1 : 0);
      if (!exp_ok)      check(tag, "exception timing (R5)", exc_cyc, acc_cyc + 1);
      else if (exp_err) check(tag, "bus error timing (R8)", err_cyc, rv_cyc + 1);
      else              check(tag, "done timing (R9)", done_cyc, rv_cyc + 1);
   endtask

   // R10: a second request held while busy is ignored
   task automatic busy_ignore();
      @(negedge clk);
      clear_log();
      err_at = -1; stall_left = 3; gnt_always = 0;
      st_addr = 32'h1006; st_size = 2'd2; st_wdata = 64'h0000_0000_CAFE_F00D;
      auth_base = 32'h1000; auth_top = 32'h2000; auth_wperm = 1'b1; st_valid = 1'b1;
      @(negedge clk);
      st_addr = 32'h1100; st_size = 2'd0;
      for (int k = 0; k < 4; k++) begin
         check("R10", "ready low while busy", st_ready, 0);
         @(negedge clk);
      end
      st_valid = 1'b0;
      repeat (30) @(negedge clk);
      check("R10", "transactions while busy", n_txn, 2);
      check("R10", "piece 0 address kept", t_addr[0], 32'h1004);
      check("R10", "piece 1 address kept", t_addr[1], 32'h1008);
      check("R10", "single done", n_done, 1);
   endtask

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_size = '0; st_wdata = '0;
      auth_base = '0; auth_top = '0; auth_wperm = 1'b0;
      bus_gnt = 1'b0; bus_rvalid = 1'b0; bus_err_in = 1'b0;
      clear_log();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11", "ready", st_ready, 1);
      check("R11", "bus request", bus_req, 0);
      check("R11", "pulses", {done, cap_exc, bus_err_out}, 0);

      run_store("R1", 32'h1000, 2'd2, 64'h0000_0000_A1B2_C3D4, 32'h1000, 32'h2000, 1, 1, -1, 0, 0);
      run_store("R1", 32'h1003, 2'd0, 64'h0000_0000_0000_005A, 32'h1000, 32'h2000, 1, 1, -1, 0, 0);
      run_store("R2", 32'h1006, 2'd2, 64'h0000_0000_1234_5678, 32'h1000, 32'h2000, 1, 1, -1, 0, 0);
      run_store("R2", 32'h100B, 2'd1, 64'h0000_0000_0000_BEEF, 32'h1000, 32'h2000, 1, 1, -1, 0, 0);
      run_store("R2", 32'h1001, 2'd1, 64'h0000_0000_0000_7788, 32'h1000, 32'h2000, 1, 1, -1, 0, 0);
      run_store("R3", 32'h1010, 2'd3, 64'h1122_3344_5566_7788, 32'h1000, 32'h2000, 1, 1, -1, 0, 0);
      run_store("R4", 32'h1FFC, 2'd2, 64'h0000_0000_0BAD_F00D, 32'h1000, 32'h2000, 1, 1, -1, 0, 0);
      run_store("R4", 32'h1FFE, 2'd2, 64'h0000_0000_0BAD_F00D, 32'h1000, 32'h2000, 1, 0, -1, 0, 0);
      run_store("R4", 32'h0FFF, 2'd0, 64'h0000_0000_0000_0011, 32'h1000, 32'h2000, 1, 0, -1, 0, 0);
      run_store("R4", 32'h1000, 2'd2, 64'h0000_0000_0000_0022, 32'h1000, 32'h2000, 0, 0, -1, 0, 0);
      run_store("R4", 32'h1012, 2'd3, 64'h0102_0304_0506_0708, 32'h1000, 32'h2000, 1, 0, -1, 0, 0);
      run_store("R6", 32'h1020, 2'd2, 64'h0000_0000_5555_AAAA, 32'h1000, 32'h2000, 1, 1, -1, 3, 0);
      run_store("R6", 32'h1030, 2'd3, 64'hDEAD_BEEF_0123_4567, 32'h1000, 32'h2000, 1, 1, -1, 0, 1);
      run_store("R8", 32'h1006, 2'd2, 64'h0000_0000_1357_9BDF, 32'h1000, 32'h2000, 1, 1, 0, 0, 0);
      run_store("R8", 32'h1006, 2'd2, 64'h0000_0000_2468_ACE0, 32'h1000, 32'h2000, 1, 1, 1, 0, 0);
      run_store("R7", 32'h1017, 2'd1, 64'h0000_0000_0000_9911, 32'h1000, 32'h2000, 1, 1, -1, 2, 0);
      busy_ignore();

      report();
      $finish;
   end
endmodule